// File: doc/BRIEF.md
# Load Data Byte Formatter

This block sits on the writeback side of a 64-bit core and turns raw doublewords coming back from the load/store path into the value that is written to a register. For every output byte a full byte-wide selector can pick any input byte, so moving the requested bytes down to the low end of the word and reversing their order for byte-swapped loads happen in one stage. Behind that selector, per-byte lane logic clears the bytes above the access size or fills them with copies of the sign bit.

Loads that straddle a doubleword boundary arrive as two beats. The first beat is rotated and parked in a holding register together with its controls; when the second beat arrives, each lane takes its byte either from the parked copy or from the new beat, depending on which doubleword that byte lives in. This also works for byte-swapped loads. When the record flag is set, the final 64-bit value is also classified as negative, positive or zero to form a 4-bit condition field for the condition register.

Top module: `ldfmt_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_cr_valid`, `out_data` and `out_cr` are all zero.
- R2: The access size is `1 << in_len` bytes (code 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). Without byte reversal, result byte i (i below the size) equals input byte `in_offset + i`, with byte 0 at bits 7:0.
- R3: When sign extension is off, all result bytes at or above the access size are zero.
- R4: When sign extension is on, all result bytes at or above the access size are copies of bit 7 of result byte (size - 1), which is taken after any reversal.
- R5: With `in_brev` set, result byte i equals the byte at access position (size - 1 - i), so the lowest-addressed byte lands in the most significant byte of the access.
- R6: A beat with `in_second_pending` set that is not itself a second beat is parked and produces no output in the following cycle.
- R7: On the beat after a parked beat, access positions p with `offset + p < 8` come from the parked doubleword and the rest from byte `offset + p - 8` of the new one. This holds with or without reversal.
- R8: `out_valid` is high for exactly one cycle, one clock after the last beat of an access. Offset, size, sign, reversal, record and overflow-flag inputs that come with a second beat are ignored; the values latched with the first beat are used.
- R9: `out_cr_valid` is high with `out_valid` only when the record flag was set. `out_cr` is {LT, GT, EQ, SO} in bits 3..0: LT = bit 63 of the result, GT = non-zero and not negative, EQ = result zero.
- R10: The SO bit of `out_cr` copies `in_so` from the first beat of the access.
- R11: A single-beat access whose bytes run past byte 7 wraps around to byte 0 of the same doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A doubleword beat is present |
| in_data | input | 64 | Raw doubleword, byte 0 in bits 7:0 |
| in_offset | input | 3 | Byte offset of the access in the doubleword |
| in_len | input | 2 | Size code, size = 1 << code bytes |
| in_sext | input | 1 | Sign-extend the result |
| in_brev | input | 1 | Reverse the byte order of the access |
| in_second_pending | input | 1 | This beat is the first of two |
| in_record | input | 1 | Produce a condition field |
| in_so | input | 1 | Summary-overflow bit to copy into the field |
| out_valid | output | 1 | Result valid, one cycle |
| out_data | output | 64 | Formatted register value |
| out_cr_valid | output | 1 | Condition field valid |
| out_cr | output | 4 | {LT, GT, EQ, SO} |

## Verification
The two functions that can fall into the same cycle are the closing of a split access, where parked lanes and new lanes are merged, and the start of an unrelated single-beat access in the cycle right after it. The bench drives such pairs back to back, and it drives a split access whose second beat carries different controls, then compares both results against a byte-level model. It also closes a split access under the record flag, so that the merge, the sign extension and the zero test all settle in the same cycle, and checks the condition field against the merged value.

// File: rtl/ldfmt_pkg.sv
// Package: shared constants and size-code type for the load data formatter.
// Assumes a little-endian byte numbering inside a doubleword (byte 0 = bits 7:0).
package ldfmt_pkg;
    localparam int LF_BYTES = 8;          // bytes per doubleword
    localparam int LF_CRW   = 4;          // condition field width

    // Access size codes; size in bytes is 1 << code
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ldfmt_size_e;
endpackage

// File: rtl/ldfmt_xbar.sv
// Module: byte crossbar. Every output lane has its own BYTES-to-1 byte mux and
// picks the input byte at (offset + position) mod BYTES, where position is the
// lane index or, for reversed loads, (size - 1 - lane). It also reports, per lane,
// whether the source byte lies in the first doubleword (no wrap past the top).
// Assumes: lanes at or above the access size are don't-care downstream.
module ldfmt_xbar #(
    parameter int BYTES = ldfmt_pkg::LF_BYTES,
    localparam int OFFW = $clog2(BYTES),
    localparam int LENW = $clog2(OFFW + 1)
) (
    input  logic [BYTES*8-1:0] din,
    input  logic [OFFW-1:0]    off,
    input  logic [LENW-1:0]    len_code,
    input  logic               brev,
    output logic [BYTES*8-1:0] dout,
    output logic [BYTES-1:0]   lo_half
);
    logic [OFFW:0] nbytes;

    // Decode the size code into a byte count
    assign nbytes = (OFFW + 1)'(1) << len_code;

    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        logic [OFFW:0]   pos_in_acc;
        logic [OFFW:0]   abs_pos;
        logic [OFFW-1:0] src;
        logic [7:0]      lane;

        // Work out which access position, and which input byte, feeds this lane
        always_comb begin
            pos_in_acc = brev ? (nbytes - (OFFW + 1)'(j + 1)) : (OFFW + 1)'(j);
            abs_pos    = {1'b0, off} + pos_in_acc;
            src        = abs_pos[OFFW-1:0];
        end

        // Per-lane byte selector over all input bytes
        always_comb begin
            lane = '0;
            for (int s = 0; s < BYTES; s++) begin
                if (src == OFFW'(s)) lane = din[s*8 +: 8];
            end
        end

        assign dout[j*8 +: 8] = lane;
        assign lo_half[j]     = ~abs_pos[OFFW];
    end
endmodule

// File: rtl/ldfmt_shape.sv
// Module: lane shaper. Merges parked and current rotated bytes for split
// accesses, then keeps the bytes inside the access size and fills the rest with
// zero or with the sign bit of the top byte of the access.
// Assumes: rotated inputs come from ldfmt_xbar with identical controls.
module ldfmt_shape #(
    parameter int BYTES = ldfmt_pkg::LF_BYTES,
    localparam int OFFW = $clog2(BYTES),
    localparam int LENW = $clog2(OFFW + 1)
) (
    input  logic [BYTES*8-1:0] cur,
    input  logic [BYTES*8-1:0] held,
    input  logic [BYTES-1:0]   lo_half,
    input  logic               splice_en,
    input  logic [LENW-1:0]    len_code,
    input  logic               sext,
    output logic [BYTES*8-1:0] res
);
    logic [OFFW:0]       nbytes;
    logic [BYTES*8-1:0]  merged;
    logic                sign;

    // Byte count from the size code
    assign nbytes = (OFFW + 1)'(1) << len_code;

    // Splice: lanes whose byte lives in the first doubleword take the parked copy
    for (genvar j = 0; j < BYTES; j++) begin : g_merge
        assign merged[j*8 +: 8] = (splice_en && lo_half[j]) ? held[j*8 +: 8] : cur[j*8 +: 8];
    end

    // Pick the sign bit from the most significant byte of the access
    always_comb begin
        sign = 1'b0;
        for (int j = 0; j < BYTES; j++) begin
            if ((OFFW + 1)'(j + 1) == nbytes) sign = merged[j*8 + 7];
        end
    end

    // Trim or extend every lane above the access size
    for (genvar j = 0; j < BYTES; j++) begin : g_trim
        assign res[j*8 +: 8] = ((OFFW + 1)'(j) < nbytes) ? merged[j*8 +: 8] : {8{sext & sign}};
    end
endmodule

// File: rtl/ldfmt_cond.sv
// Module: condition classifier. Produces {LT, GT, EQ, SO} from the final value.
// Assumes: the value is a two's-complement number of W bits.
module ldfmt_cond #(
    parameter int W   = ldfmt_pkg::LF_BYTES * 8,
    parameter int CRW = ldfmt_pkg::LF_CRW
) (
    input  logic [W-1:0]   value,
    input  logic           so,
    output logic [CRW-1:0] cr
);
    logic is_zero;
    logic is_neg;

    // Zero and sign detection on the full width
    assign is_zero = (value == '0);
    assign is_neg  = value[W-1];

    // Pack the field, SO in the lowest bit
    assign cr = {is_neg, ~is_neg & ~is_zero, is_zero, so};
endmodule

// File: rtl/ldfmt_top.sv
// Module: load data formatter top. Steers one or two doubleword beats into a
// register value with one cycle of latency after the last beat, and classifies
// the value for the condition register when the record flag is set.
// Assumes: a beat with the second-pending flag is always followed by a second
// beat; controls presented with the second beat are not used.
module ldfmt_top #(
    parameter int BYTES = ldfmt_pkg::LF_BYTES,
    localparam int W    = BYTES * 8,
    localparam int OFFW = $clog2(BYTES),
    localparam int LENW = $clog2(OFFW + 1),
    localparam int CRW  = ldfmt_pkg::LF_CRW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    in_data,
    input  logic [OFFW-1:0] in_offset,
    input  logic [LENW-1:0] in_len,
    input  logic            in_sext,
    input  logic            in_brev,
    input  logic            in_second_pending,
    input  logic            in_record,
    input  logic            in_so,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            out_cr_valid,
    output logic [CRW-1:0]  out_cr
);
    // Parked state for a split access
    logic            pend_q;
    logic [OFFW-1:0] off_q;
    logic [LENW-1:0] len_q;
    logic            sext_q, brev_q, rec_q, so_q;
    logic [W-1:0]    held_q;

    // Controls in use this cycle
    logic [OFFW-1:0] u_off;
    logic [LENW-1:0] u_len;
    logic            u_sext, u_brev, u_rec, u_so;

    logic [W-1:0]     rot;
    logic [BYTES-1:0] lo_half;
    logic [W-1:0]     res;
    logic [CRW-1:0]   cr;
    logic             start_split;
    logic             fire;

    // A second beat uses the controls latched with its first beat
    always_comb begin
        u_off  = pend_q ? off_q  : in_offset;
        u_len  = pend_q ? len_q  : in_len;
        u_sext = pend_q ? sext_q : in_sext;
        u_brev = pend_q ? brev_q : in_brev;
        u_rec  = pend_q ? rec_q  : in_record;
        u_so   = pend_q ? so_q   : in_so;
    end

    // Beat classification: park a first half, emit on a last beat
    assign start_split = in_valid && !pend_q && in_second_pending;
    assign fire        = in_valid && (pend_q || !in_second_pending);

    ldfmt_xbar #(.BYTES(BYTES)) u_xbar (
        .din      (in_data),
        .off      (u_off),
        .len_code (u_len),
        .brev     (u_brev),
        .dout     (rot),
        .lo_half  (lo_half)
    );

    ldfmt_shape #(.BYTES(BYTES)) u_shape (
        .cur       (rot),
        .held      (held_q),
        .lo_half   (lo_half),
        .splice_en (pend_q),
        .len_code  (u_len),
        .sext      (u_sext),
        .res       (res)
    );

    ldfmt_cond #(.W(W), .CRW(CRW)) u_cond (
        .value (res),
        .so    (u_so),
        .cr    (cr)
    );

    // Holding register: capture rotated first half and its controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            off_q  <= '0;
            len_q  <= '0;
            sext_q <= 1'b0;
            brev_q <= 1'b0;
            rec_q  <= 1'b0;
            so_q   <= 1'b0;
            held_q <= '0;
        end else if (in_valid) begin
            if (start_split) begin
                pend_q <= 1'b1;
                off_q  <= in_offset;
                len_q  <= in_len;
                sext_q <= in_sext;
                brev_q <= in_brev;
                rec_q  <= in_record;
                so_q   <= in_so;
                held_q <= rot;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    // Output register: result and condition field one cycle after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_cr_valid <= 1'b0;
            out_data     <= '0;
            out_cr       <= '0;
        end else begin
            out_valid    <= fire;
            out_cr_valid <= fire && u_rec;
            if (fire) begin
                out_data <= res;
                out_cr   <= u_rec ? cr : '0;
            end
        end
    end

    // A parked first half never produces a result in the next cycle
    assert_first_half_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_split |=> !out_valid);

    // Results only appear one cycle after an input beat
    assert_valid_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // The second beat closes the split access and yields a result
    assert_second_beat_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && in_valid) |=> (out_valid && !pend_q));

    // Condition field only accompanies a result
    assert_cr_with_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_valid |-> out_valid);

    // EQ agrees with the registered value
    assert_cr_eq_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_valid |-> (out_cr[1] == (out_data == '0)));

    // Exactly one of LT, GT, EQ is set
    assert_cr_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_valid |-> $onehot(out_cr[3:1]));

    // LT follows the sign bit of the result
    assert_cr_lt_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_valid |-> (out_cr[3] == out_data[W-1]));
endmodule

// File: tb/tb_ldfmt_top.sv
`timescale 1ns/1ps
module tb_ldfmt_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic [2:0]  in_offset;
    logic [1:0]  in_len;
    logic        in_sext, in_brev, in_second_pending, in_record, in_so;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_cr_valid;
    logic [3:0]  out_cr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] DA = 64'h8877665544332211;
    localparam logic [63:0] DB = 64'h0123456789ABCDEF;

    always #2 clk = ~clk;

    ldfmt_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_offset(in_offset), .in_len(in_len), .in_sext(in_sext), .in_brev(in_brev),
        .in_second_pending(in_second_pending), .in_record(in_record), .in_so(in_so),
        .out_valid(out_valid), .out_data(out_data), .out_cr_valid(out_cr_valid), .out_cr(out_cr)
    );

    // Byte-level model of the requirements
    function automatic logic [63:0] model(input logic [63:0] d0, input logic [63:0] d1,
                                          input int off, input int lc, input bit sext,
                                          input bit brev, input bit split);
        int sz = 1 << lc;
        logic [63:0] r = '0;
        logic sg;
        for (int i = 0; i < sz; i++) begin
            int p = brev ? (sz - 1 - i) : i;
            int a = off + p;
            if (a < 8)      r[i*8 +: 8] = d0[a*8 +: 8];
            else if (split) r[i*8 +: 8] = d1[(a-8)*8 +: 8];
            else            r[i*8 +: 8] = d0[(a-8)*8 +: 8];
        end
        sg = r[sz*8-1];
        for (int i = sz; i < 8; i++) r[i*8 +: 8] = (sext && sg) ? 8'hFF : 8'h00;
        return r;
    endfunction

    function automatic logic [3:0] cr_model(input logic [63:0] v, input bit so);
        return {v[63], (!v[63] && v != 0), (v == 0), so};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 0; in_data = '0; in_offset = '0; in_len = '0; in_sext = 0;
        in_brev = 0; in_second_pending = 0; in_record = 0; in_so = 0;
    endtask

    task automatic drive(input logic [63:0] d, input int off, input int lc, input bit sext,
                         input bit brev, input bit pend, input bit rec, input bit so);
        in_valid = 1; in_data = d; in_offset = 3'(off); in_len = 2'(lc); in_sext = sext;
        in_brev = brev; in_second_pending = pend; in_record = rec; in_so = so;
    endtask

    // One single-beat access, result checked one cycle later
    task automatic single(input string req, input logic [63:0] d, input int off, input int lc,
                          input bit sext, input bit brev, input bit rec, input bit so);
        logic [63:0] e = model(d, '0, off, lc, sext, brev, 1'b0);
        @(negedge clk); drive(d, off, lc, sext, brev, 0, rec, so);
        @(negedge clk); idle();
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " data"}, out_data, e);
        chk({req, " cr_valid"}, 64'(out_cr_valid), 64'(rec));
        if (rec) chk({req, " cr"}, 64'(out_cr), 64'(cr_model(e, so)));
    endtask

    // Two-beat access; the second beat carries different, ignored controls
    task automatic split(input string req, input logic [63:0] d0, input logic [63:0] d1,
                         input int off, input int lc, input bit sext, input bit brev,
                         input bit rec, input bit so);
        logic [63:0] e = model(d0, d1, off, lc, sext, brev, 1'b1);
        @(negedge clk); drive(d0, off, lc, sext, brev, 1, rec, so);
        @(negedge clk);
        chk({req, " R6 first half silent"}, 64'(out_valid), 64'd0);
        drive(d1, (off + 3) % 8, 0, !sext, !brev, 0, !rec, !so);
        @(negedge clk); idle();
        chk({req, " R8 valid"}, 64'(out_valid), 64'd1);
        chk({req, " data"}, out_data, e);
        chk({req, " R8 cr_valid"}, 64'(out_cr_valid), 64'(rec));
        if (rec) chk({req, " R10 cr"}, 64'(out_cr), 64'(cr_model(e, so)));
        @(negedge clk);
        chk({req, " R8 single pulse"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 data", out_data, 64'd0);
        chk("R1 cr_valid", 64'(out_cr_valid), 64'd0);
        chk("R1 cr", 64'(out_cr), 64'd0);
    endtask

    task automatic t_aligned();
        single("R2 dword", DA, 0, 3, 0, 0, 0, 0);
        single("R2 R3 half at 4", DA, 4, 1, 0, 0, 0, 0);
        single("R3 word zero fill", DB, 4, 2, 0, 0, 0, 0);
    endtask

    task automatic t_sign();
        single("R4 byte negative", DA, 7, 0, 1, 0, 0, 0);
        single("R4 word positive", DA, 0, 2, 1, 0, 0, 0);
        single("R4 half negative", DB, 2, 1, 1, 0, 0, 0);
    endtask

    task automatic t_reverse();
        single("R5 word reversed", DA, 0, 2, 0, 0 + 1, 0, 0);
        single("R5 R4 half reversed sign", DB, 0, 1, 1, 1, 0, 0);
        single("R5 dword reversed", DB, 0, 3, 0, 1, 0, 0);
    endtask

    task automatic t_splice();
        split("R7 dword at 5", DA, DB, 5, 3, 0, 0, 0, 0);
        split("R7 half at 7 sext", DB, DA, 7, 1, 1, 0, 0, 0);
    endtask

    task automatic t_splice_rev();
        split("R7 reversed word at 6", DA, DB, 6, 2, 0, 1, 0, 0);
        split("R7 reversed dword at 3 rec", DB, DA, 3, 3, 1, 1, 1, 1);
    endtask

    task automatic t_wrap();
        single("R11 word wraps at 6", DA, 6, 2, 0, 0, 0, 0);
        single("R11 reversed dword at 2", DA, 2, 3, 0, 1, 0, 0);
    endtask

    task automatic t_record();
        single("R9 zero", 64'hFFFF_FFFF_FFFF_FF00, 0, 0, 1, 0, 1, 0);
        single("R9 R10 negative so", DA, 0, 3, 0, 0, 1, 1);
        single("R9 positive", DA, 0, 2, 0, 0, 1, 0);
        single("R9 no record", DA, 0, 3, 0, 0, 0, 1);
        split("R9 R10 split record", DA, DB, 5, 3, 0, 0, 1, 1);
    endtask

    // A split access closes and a single-beat access follows in the next cycle
    task automatic t_back2back();
        logic [63:0] e1 = model(DA, DB, 4, 3, 0, 1, 1'b1);
        logic [63:0] e2 = model(DB, '0, 1, 1, 1, 0, 1'b0);
        @(negedge clk); drive(DA, 4, 3, 0, 1, 1, 1, 0);
        @(negedge clk); drive(DB, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk); drive(DB, 1, 1, 1, 0, 0, 0, 0);
        chk("R8 b2b first valid", 64'(out_valid), 64'd1);
        chk("R7 b2b first data", out_data, e1);
        chk("R9 b2b first cr", 64'(out_cr), 64'(cr_model(e1, 1'b0)));
        @(negedge clk); idle();
        chk("R8 b2b second valid", 64'(out_valid), 64'd1);
        chk("R4 b2b second data", out_data, e2);
        chk("R9 b2b second no cr", 64'(out_cr_valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_sign();
        t_reverse();
        t_splice();
        t_splice_rev();
        t_wrap();
        t_record();
        t_back2back();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            finish_run();
        end
    end
endmodule